// File: doc/BRIEF.md
# Channel Status Capture and Decode

This block sits behind the biphase decoder of an S/PDIF or AES3 receiver. For every decoded sub-frame it receives a strobe, the sub-frame's position in the frame (first or second channel), the channel-status (C) bit and a flag that marks the Z preamble, which opens a 192-frame block. From one selectable channel it gathers the C bits of frames 0 to 31 into a 32-bit word. The word becomes visible only when all 32 bits of a block are in.

The visible word is decoded into a professional/consumer flag, a two-bit sampling-rate code and a pre-emphasis flag, using the field layout that bit 0 selects. A de-emphasis selector then drives an enable and a rate code to a downstream filter. These come either from the decoded status or, when automatic mode is off, from manual control inputs. A block-start flag covers frames 0 to 31 of each block.

Top module: `chstat_rx`

## Requirements
- R1: Bit i of `status_word_o` is the C bit of frame i (i = 0..31) of the selected channel. The word changes only at the clock edge that samples the strobe carrying frame 31 of that channel, and then holds the full new word.
- R2: With `src_sel_i` = 0, sub-frames with `sub_chan_i` = 0 are captured; with 1, sub-frames with `sub_chan_i` = 1 are captured. `src_sel_i` is sampled with the block-start sub-frame, so a change mid-block takes effect from the next block.
- R3: `blk_flag_o` rises at the edge sampling a `sub_chan_i` = 0 strobe with `blk_start_i` = 1 (frame 0). It stays high through frame 31 and falls at the edge sampling the `sub_chan_i` = 0 strobe of frame 32.
- R4: Consumer decode (bit 0 = 0). `pre_emph_o` = 1 only when bits 5,4,3 = 0,0,1. `fs_code_o` is taken from bits 24,25,26,27: 0,0,0,0 gives 00 (44.1 kHz); 0,1,0,0 gives 01 (48 kHz); 1,1,0,0 gives 10 (32 kHz); 0,1,0,1 gives 11 (96 kHz); any other pattern gives 00.
- R5: Professional decode (bit 0 = 1, `pro_mode_o` = 1). `pre_emph_o` = 1 only when bits 2,3,4 = 1,1,0. `fs_code_o` is taken from bits 6,7: 1,0 gives 00; 0,1 gives 01; 1,1 gives 10; 0,0 gives 00.
- R6: With `auto_deemph_i` = 1, `deemph_en_o` and `deemph_rate_o` equal `pre_emph_o` and `fs_code_o` as they stood one clock earlier.
- R7: With `auto_deemph_i` = 0, `deemph_en_o` and `deemph_rate_o` equal `man_deemph_en_i` and `man_rate_i` one clock later, whatever the status word holds.
- R8: Reset clears the status word, `blk_flag_o` and `deemph_en_o`, and sets `deemph_rate_o` to 00.
- R9: If 192 frames pass without a new block start, capture stops and `blk_flag_o` stays low until the next block start.
- R10: A block cut short by a new block start before frame 31 leaves `status_word_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sub_valid_i | input | 1 | One-cycle strobe per decoded sub-frame |
| sub_chan_i | input | 1 | 0 = first sub-frame of the frame, 1 = second |
| cbit_i | input | 1 | Channel-status bit of this sub-frame |
| blk_start_i | input | 1 | Z preamble seen on this sub-frame |
| src_sel_i | input | 1 | Channel to capture |
| auto_deemph_i | input | 1 | 1 = de-emphasis from status, 0 = manual |
| man_deemph_en_i | input | 1 | Manual de-emphasis enable |
| man_rate_i | input | 2 | Manual de-emphasis rate code |
| status_word_o | output | 32 | Last complete captured status word |
| pro_mode_o | output | 1 | Professional layout in use |
| fs_code_o | output | 2 | Decoded sampling-rate code |
| pre_emph_o | output | 1 | Decoded pre-emphasis indication |
| blk_flag_o | output | 1 | High for frames 0 to 31 of a block |
| deemph_en_o | output | 1 | De-emphasis filter enable |
| deemph_rate_o | output | 2 | De-emphasis filter rate code |

## Verification
The status word and the block flag are registered at the edge that samples the relevant strobe. The decoded fields follow the word in the same cycle, and the de-emphasis outputs lag one more clock. The driver applies each strobe on a falling edge, holds it for one cycle and then samples at the next falling edge, where the registered results are already settled. The monitor compares each change of the status word against the queue head the driver pushed before the frame-31 strobe. De-emphasis checks wait at least two falling edges after any change to their inputs.

// File: rtl/chstat_pkg.sv
package chstat_pkg;
  localparam int unsigned CS_BITS = 32;
  localparam int unsigned IDX_W   = $clog2(CS_BITS);

  typedef logic [CS_BITS-1:0] cs_word_t;

  typedef enum logic [1:0] {
    RATE_44K1 = 2'b00,
    RATE_48K  = 2'b01,
    RATE_32K  = 2'b10,
    RATE_96K  = 2'b11
  } rate_e;

  typedef struct packed {
    logic  pro;
    rate_e rate;
    logic  emph;
  } cs_fields_t;
endpackage

// File: rtl/chstat_frame_trk.sv
module chstat_frame_trk
  import chstat_pkg::*;
#(
  parameter int unsigned BLOCK_FRAMES = 192,
  parameter int unsigned FLAG_FRAMES  = CS_BITS,
  localparam int unsigned FW = $clog2(BLOCK_FRAMES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sub_valid_i,
  input  logic             sub_chan_i,
  input  logic             blk_start_i,
  input  logic             src_sel_i,
  output logic             cap_en_o,
  output logic [IDX_W-1:0] cap_idx_o,
  output logic             cap_last_o,
  output logic             blk_flag_o
);
  logic [FW-1:0] frame_q, frame_d;
  logic          sync_q, sync_d;
  logic          sel_q, sel_d;
  logic          flag_q, flag_d;
  logic          lead, zmark;

  assign lead  = sub_valid_i && !sub_chan_i;
  assign zmark = lead && blk_start_i;

  always_comb begin
    frame_d = frame_q;
    sync_d  = sync_q;
    sel_d   = sel_q;
    if (zmark) begin
      frame_d = '0;
      sync_d  = 1'b1;
      sel_d   = src_sel_i;
    end else if (lead && sync_q) begin
      // block overran without a Z: drop alignment
      if (frame_q == FW'(BLOCK_FRAMES - 1)) sync_d = 1'b0;
      frame_d = frame_q + 1'b1;
    end
  end

  always_comb begin
    flag_d = flag_q;
    if (zmark)                                   flag_d = 1'b1;
    else if (lead && (!sync_d || frame_d == FW'(FLAG_FRAMES))) flag_d = 1'b0;
  end

  assign cap_en_o   = sub_valid_i && sync_d && (frame_d < FW'(CS_BITS)) &&
                      (sub_chan_i == sel_d);
  assign cap_idx_o  = frame_d[IDX_W-1:0];
  assign cap_last_o = (cap_idx_o == IDX_W'(CS_BITS - 1));
  assign blk_flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      sync_q  <= 1'b0;
      sel_q   <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      frame_q <= frame_d;
      sync_q  <= sync_d;
      sel_q   <= sel_d;
      flag_q  <= flag_d;
    end
  end
endmodule

// File: rtl/chstat_collect.sv
module chstat_collect
  import chstat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_en_i,
  input  logic [IDX_W-1:0] cap_idx_i,
  input  logic             cap_last_i,
  input  logic             cbit_i,
  output cs_word_t         word_o
);
  cs_word_t shadow_q, shadow_d;
  cs_word_t word_q;

  always_comb begin
    shadow_d = shadow_q;
    shadow_d[cap_idx_i] = cbit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      word_q   <= '0;
    end else if (cap_en_i) begin
      shadow_q <= shadow_d;
      if (cap_last_i) word_q <= shadow_d;
    end
  end

  assign word_o = word_q;
endmodule

// File: rtl/chstat_decode.sv
module chstat_decode
  import chstat_pkg::*;
(
  input  cs_word_t   word_i,
  output cs_fields_t fld_o
);
  rate_e con_rate, pro_rate;
  logic  con_emph, pro_emph;

  always_comb begin
    unique case ({word_i[24], word_i[25], word_i[26], word_i[27]})
      4'b0100: con_rate = RATE_48K;
      4'b1100: con_rate = RATE_32K;
      4'b0101: con_rate = RATE_96K;
      default: con_rate = RATE_44K1;
    endcase
    unique case ({word_i[6], word_i[7]})
      2'b01:   pro_rate = RATE_48K;
      2'b11:   pro_rate = RATE_32K;
      default: pro_rate = RATE_44K1;
    endcase
  end

  assign con_emph = ({word_i[5], word_i[4], word_i[3]} == 3'b001);
  assign pro_emph = ({word_i[2], word_i[3], word_i[4]} == 3'b110);

  assign fld_o.pro  = word_i[0];
  assign fld_o.rate = word_i[0] ? pro_rate : con_rate;
  assign fld_o.emph = word_i[0] ? pro_emph : con_emph;
endmodule

// File: rtl/chstat_deemph_sel.sv
module chstat_deemph_sel
  import chstat_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       auto_i,
  input  cs_fields_t fld_i,
  input  logic       man_en_i,
  input  logic [1:0] man_rate_i,
  output logic       en_o,
  output rate_e      rate_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      rate_o <= RATE_44K1;
    end else if (auto_i) begin
      en_o   <= fld_i.emph;
      rate_o <= fld_i.rate;
    end else begin
      en_o   <= man_en_i;
      rate_o <= rate_e'(man_rate_i);
    end
  end
endmodule

// File: rtl/chstat_rx.sv
module chstat_rx
  import chstat_pkg::*;
#(
  parameter int unsigned BLOCK_FRAMES = 192,
  parameter int unsigned FLAG_FRAMES  = CS_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sub_valid_i,
  input  logic               sub_chan_i,
  input  logic               cbit_i,
  input  logic               blk_start_i,
  input  logic               src_sel_i,
  input  logic               auto_deemph_i,
  input  logic               man_deemph_en_i,
  input  logic [1:0]         man_rate_i,
  output logic [CS_BITS-1:0] status_word_o,
  output logic               pro_mode_o,
  output logic [1:0]         fs_code_o,
  output logic               pre_emph_o,
  output logic               blk_flag_o,
  output logic               deemph_en_o,
  output logic [1:0]         deemph_rate_o
);
  logic             cap_en, cap_last;
  logic [IDX_W-1:0] cap_idx;
  cs_word_t         word;
  cs_fields_t       fld;
  rate_e            dm_rate;

  chstat_frame_trk #(
    .BLOCK_FRAMES(BLOCK_FRAMES),
    .FLAG_FRAMES (FLAG_FRAMES)
  ) u_trk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sub_valid_i(sub_valid_i),
    .sub_chan_i (sub_chan_i),
    .blk_start_i(blk_start_i),
    .src_sel_i  (src_sel_i),
    .cap_en_o   (cap_en),
    .cap_idx_o  (cap_idx),
    .cap_last_o (cap_last),
    .blk_flag_o (blk_flag_o)
  );

  chstat_collect u_col (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_en_i  (cap_en),
    .cap_idx_i (cap_idx),
    .cap_last_i(cap_last),
    .cbit_i    (cbit_i),
    .word_o    (word)
  );

  chstat_decode u_dec (
    .word_i(word),
    .fld_o (fld)
  );

  chstat_deemph_sel u_dm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .auto_i    (auto_deemph_i),
    .fld_i     (fld),
    .man_en_i  (man_deemph_en_i),
    .man_rate_i(man_rate_i),
    .en_o      (deemph_en_o),
    .rate_o    (dm_rate)
  );

  assign status_word_o = word;
  assign pro_mode_o    = fld.pro;
  assign fs_code_o     = fld.rate;
  assign pre_emph_o    = fld.emph;
  assign deemph_rate_o = dm_rate;
endmodule

// File: rtl/chstat_rx_chk.sv
module chstat_rx_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sub_valid_i,
  input logic        sub_chan_i,
  input logic        blk_start_i,
  input logic        auto_deemph_i,
  input logic        man_deemph_en_i,
  input logic [1:0]  man_rate_i,
  input logic [31:0] status_word_o,
  input logic [1:0]  fs_code_o,
  input logic        pre_emph_o,
  input logic        blk_flag_o,
  input logic        deemph_en_o,
  input logic [1:0]  deemph_rate_o
);
  // R1
  status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_word_o) |-> $past(sub_valid_i));

  // R3
  blk_flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blk_flag_o) |-> $past(sub_valid_i && !sub_chan_i && blk_start_i));

  // R3
  blk_flag_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_valid_i |=> $stable(blk_flag_o));

  // R6
  auto_deemph_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_deemph_i |=> (deemph_en_o == $past(pre_emph_o)) &&
                      (deemph_rate_o == $past(fs_code_o)));

  // R7
  man_deemph_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_deemph_i |=> (deemph_en_o == $past(man_deemph_en_i)) &&
                       (deemph_rate_o == $past(man_rate_i)));
endmodule

bind chstat_rx chstat_rx_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sub_valid_i    (sub_valid_i),
  .sub_chan_i     (sub_chan_i),
  .blk_start_i    (blk_start_i),
  .auto_deemph_i  (auto_deemph_i),
  .man_deemph_en_i(man_deemph_en_i),
  .man_rate_i     (man_rate_i),
  .status_word_o  (status_word_o),
  .fs_code_o      (fs_code_o),
  .pre_emph_o     (pre_emph_o),
  .blk_flag_o     (blk_flag_o),
  .deemph_en_o    (deemph_en_o),
  .deemph_rate_o  (deemph_rate_o)
);

// File: tb/chstat_rx_test.sv
`timescale 1ns/1ps
module chstat_rx_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sub_valid_i = 1'b0, sub_chan_i = 1'b0, cbit_i = 1'b0, blk_start_i = 1'b0;
  logic        src_sel_i = 1'b0, auto_deemph_i = 1'b1, man_deemph_en_i = 1'b0;
  logic [1:0]  man_rate_i = 2'b00;
  logic [31:0] status_word_o;
  logic        pro_mode_o, pre_emph_o, blk_flag_o, deemph_en_o;
  logic [1:0]  fs_code_o, deemph_rate_o;

  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  logic [31:0] last_word = '0;
  bit mon_on = 0;
  bit done = 0;

  chstat_rx uut (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: each change of the status word must match the queue head
  always @(negedge clk_i) begin
    if (mon_on && status_word_o !== last_word) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected update", status_word_o, last_word);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(status_word_o === e, "R1/R2 captured word", status_word_o, e);
      end
      last_word = status_word_o;
    end
  end

  task automatic send_sub(input bit chan, input bit c, input bit z);
    @(negedge clk_i);
    sub_valid_i = 1'b1; sub_chan_i = chan; cbit_i = c; blk_start_i = z;
    @(negedge clk_i);
    sub_valid_i = 1'b0; blk_start_i = 1'b0;
  endtask

  task automatic send_block(input logic [31:0] wa, input logic [31:0] wb, input int nfr,
                            input bit z0, input bit commit, input bit flip_at5);
    bit bsel;
    bsel = src_sel_i;
    for (int f = 0; f < nfr; f++) begin
      bit ca, cb;
      ca = (f < 32) ? wa[f] : f[0];
      cb = (f < 32) ? wb[f] : f[1];
      if (f == 5 && flip_at5) src_sel_i = ~src_sel_i;
      if (f == 31 && commit) exp_q.push_back(bsel ? wb : wa);
      send_sub(1'b0, ca, (f == 0) && z0);
      if (z0 && f == 0)  chk(blk_flag_o === 1'b1, "R3 flag high at frame 0", blk_flag_o, 1);
      if (z0 && f == 32) chk(blk_flag_o === 1'b0, "R3 flag low at frame 32", blk_flag_o, 0);
      send_sub(1'b1, cb, 1'b0);
      if (z0 && f == 31) chk(blk_flag_o === 1'b1, "R3 flag high through frame 31", blk_flag_o, 1);
    end
    repeat (2) @(negedge clk_i);
  endtask

  task automatic chk_fields(input string req, input bit pro, input logic [1:0] fs, input bit pe);
    chk(pro_mode_o === pro, {req, " pro"}, pro_mode_o, pro);
    chk(fs_code_o === fs, {req, " fs"}, fs_code_o, fs);
    chk(pre_emph_o === pe, {req, " emph"}, pre_emph_o, pe);
    chk(deemph_en_o === pe, "R6 auto enable", deemph_en_o, pe);
    chk(deemph_rate_o === fs, "R6 auto rate", deemph_rate_o, fs);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R8 reset state
    chk(status_word_o === 32'h0, "R8 word", status_word_o, 0);
    chk(blk_flag_o === 1'b0, "R8 flag", blk_flag_o, 0);
    chk(deemph_en_o === 1'b0, "R8 deemph en", deemph_en_o, 0);
    chk(deemph_rate_o === 2'b00, "R8 deemph rate", deemph_rate_o, 0);
    mon_on = 1;

    // R4 consumer 48k, channel 1
    src_sel_i = 1'b0;
    send_block(32'h0200_0000, 32'h0000_0F00, 192, 1, 1, 0);
    chk_fields("R4 48k", 0, 2'b01, 0);

    // R2 channel 2, consumer 32k with emphasis
    src_sel_i = 1'b1;
    send_block(32'h1234_5670, 32'h0300_0008, 192, 1, 1, 0);
    chk_fields("R4 32k emph", 0, 2'b10, 1);

    // R2 mid-block source change applies next block; R4 96k
    src_sel_i = 1'b0;
    send_block(32'h0A00_0000, 32'h0000_004D, 192, 1, 1, 1);
    chk_fields("R4 96k", 0, 2'b11, 0);
    chk(src_sel_i === 1'b1, "R2 bench select flipped", src_sel_i, 1);

    // R5 professional, 44.1k code, emphasis
    send_block(32'h0200_0000, 32'h0000_004D, 192, 1, 1, 0);
    chk_fields("R5 pro emph", 1, 2'b00, 1);

    // R7 manual override
    auto_deemph_i = 1'b0; man_deemph_en_i = 1'b0; man_rate_i = 2'b11;
    repeat (2) @(negedge clk_i);
    chk(deemph_en_o === 1'b0, "R7 manual off", deemph_en_o, 0);
    chk(deemph_rate_o === 2'b11, "R7 manual rate", deemph_rate_o, 2'b11);
    man_deemph_en_i = 1'b1; man_rate_i = 2'b01;
    repeat (2) @(negedge clk_i);
    chk(deemph_en_o === 1'b1, "R7 manual on", deemph_en_o, 1);
    chk(deemph_rate_o === 2'b01, "R7 manual rate 2", deemph_rate_o, 2'b01);
    auto_deemph_i = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(deemph_en_o === 1'b1 && deemph_rate_o === 2'b00, "R6 back to auto",
        {deemph_en_o, deemph_rate_o}, 3'b100);

    // R10 partial block then full block
    send_block(32'h0, 32'h0000_0081, 20, 1, 0, 0);
    chk(status_word_o === 32'h0000_004D, "R10 partial ignored", status_word_o, 32'h4D);
    send_block(32'h0, 32'h0000_0081, 192, 1, 1, 0);
    chk_fields("R5 pro 48k", 1, 2'b01, 0);

    // R9 lost alignment
    send_block(32'h0, 32'h0A00_0000, 192, 1, 1, 0);
    send_block(32'h0, 32'h0300_0008, 40, 0, 0, 0);
    chk(status_word_o === 32'h0A00_0000, "R9 no capture unaligned", status_word_o, 32'h0A00_0000);
    chk(blk_flag_o === 1'b0, "R9 flag low unaligned", blk_flag_o, 0);
    send_block(32'h0, 32'h0300_0008, 192, 1, 1, 0);
    chk_fields("R9 realigned", 0, 2'b10, 1);

    repeat (4) @(negedge clk_i);
    chk(exp_q.size() == 0, "R1 all words seen", exp_q.size(), 0);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(negedge clk_i);
    if (!done) chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule